// File: doc/BRIEF.md
# Controller interrupt and exception unit

This unit sits beside a bus controller's message engine and turns the engine's interrupt events into outputs for software. There are two event classes. A high-priority event raises a level interrupt that stays up until software acknowledges it. When that event is a message error, the unit also raises a hold output that stalls the controller until the same acknowledge arrives. A standard event is queued. When its turn comes, the unit takes the memory bus through request/grant arbitration and logs the event in a memory-resident interrupt log with a three-step DMA burst. It then emits a one-cycle active-low pulse. If enabled, it also sets a level interrupt.

Standard events enter through a valid/ready port. An event is accepted on a cycle where both `std_evt_valid_i` and `std_evt_ready_o` are high. Ready drops only when the internal queue is full, and the engine must then hold the event and its data. The DMA command port is also valid/ready. A command's address, direction and write data stay fixed from the cycle valid rises until the cycle ready is seen. The memory side gives read data with a single `dma_rvalid_i` strobe, which comes one or more cycles after the read command is accepted. The unit keeps one read outstanding at most.

Top module: `bcx_irq_unit`

## Requirements
- R1: After reset the following outputs are low: `hp_irq_o`, `ctl_hold_o`, `std_irq_lvl_o`, `dma_req_o` and `dma_cmd_valid_o`. `std_irq_pulse_n_o` is high and `std_evt_ready_o` is high. The log pointer starts at `LOG_BASE`.
- R2: A high-priority event (`hp_evt_i` high for a cycle) sets `hp_irq_o` on the next cycle only when bit 0 of the enable register is 1. The enable register is loaded from `cfg_en_wdata_i` when `cfg_en_wr_i` is high. `hp_irq_o` then stays high until it is acknowledged.
- R3: A high-priority event with `hp_msg_err_i` high sets `ctl_hold_o` on the next cycle, whatever the enable register holds. Hold stays high until a write with bit 0 of `cfg_ack_wdata_i` set. That write clears both hold and `hp_irq_o`.
- R4: Each standard event runs one burst, and the burst starts only after `dma_gnt_i` answers `dma_req_o`. The burst issues exactly three commands in this order: a write of the status word to address P, a write of the zero-extended block pointer to P+1, and a read of P+2. P is the log pointer. `dma_req_o` stays high from the request until the read data returns.
- R5: When the read data returns, its low `AW` bits become the new log pointer. The next burst logs at that address.
- R6: `std_irq_pulse_n_o` goes low for exactly one cycle, namely the cycle right after the one in which `dma_rvalid_i` is taken.
- R7: `std_irq_lvl_o` rises in the same cycle as the pulse, and only if bit 1 of the enable register is 1. It stays high until a write with bit 1 of `cfg_ack_wdata_i` set.
- R8: Acknowledge bits are write-one-to-clear and self-clearing. A 0 in an acknowledge bit leaves its flag unchanged. A set and a clear in the same cycle leave the flag set.
- R9: No burst begins while `ctl_hold_o` is high. So when a high-priority message error and a standard event arrive together, the hold is serviced first and the logging burst waits.
- R10: Up to `QDEPTH` standard events are queued and then logged in arrival order. `std_evt_ready_o` is low only while the queue is full.
- R11: Standard events never raise `ctl_hold_o`, and the controller keeps running after them.
- R12: While `dma_cmd_valid_o` is high and `dma_cmd_ready_i` is low, the command's valid, direction, address and data hold their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_evt_i | input | 1 | High-priority event strobe |
| hp_msg_err_i | input | 1 | Qualifies the high-priority event as a message error |
| std_evt_valid_i | input | 1 | Standard event valid |
| std_evt_ready_o | output | 1 | Standard event ready (queue not full) |
| std_status_i | input | DW | Interrupt status word of the standard event |
| cur_blk_ptr_i | input | AW | Current command-block pointer |
| cfg_en_wr_i | input | 1 | Enable register write strobe |
| cfg_en_wdata_i | input | 2 | Enable bits: bit 0 high-priority, bit 1 standard level |
| cfg_ack_wr_i | input | 1 | Acknowledge register write strobe |
| cfg_ack_wdata_i | input | 2 | Acknowledge bits: bit 0 high-priority and hold, bit 1 standard level |
| hp_irq_o | output | 1 | High-priority interrupt level |
| ctl_hold_o | output | 1 | Controller stall |
| std_irq_pulse_n_o | output | 1 | Standard interrupt pulse, active low |
| std_irq_lvl_o | output | 1 | Standard interrupt level |
| dma_req_o | output | 1 | Bus request |
| dma_gnt_i | input | 1 | Bus grant |
| dma_cmd_valid_o | output | 1 | DMA command valid |
| dma_cmd_ready_i | input | 1 | DMA command ready |
| dma_cmd_we_o | output | 1 | DMA command is a write |
| dma_cmd_addr_o | output | AW | DMA command address |
| dma_cmd_wdata_o | output | DW | DMA write data |
| dma_rvalid_i | input | 1 | DMA read data strobe |
| dma_rdata_i | input | DW | DMA read data |

## Verification
Both enable bits and the message-error flag are swept together, so that an interrupt gated by its enable can be told apart from hold, which is not gated. Acknowledges with the other bit set, and acknowledges that coincide with a new event, are included so that write-one-to-clear can be told apart from write-any-to-clear and from clear-wins. Standard events are run with the command port always ready and again with a periodic stall pattern, so that a correct three-command order can be told apart from commands that slip, repeat or change under back-pressure. The memory returns an arithmetic function of the read address, so each new log address shows whether the pointer really follows the read data. A burst of events with grant withheld fills the queue and checks back-pressure and arrival order. A high-priority error arriving together with a standard event shows whether the hold is given precedence.

// File: rtl/bcx_irq_pkg.sv
package bcx_irq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ARB,
    SQ_WSTAT,
    SQ_WPTR,
    SQ_RTAIL,
    SQ_WAITR
  } seq_state_e;

  localparam int unsigned CFG_BIT_HP  = 0;
  localparam int unsigned CFG_BIT_STD = 1;
  localparam int unsigned CFG_W       = 2;
endpackage

// File: rtl/irq_evt_fifo.sv
module irq_evt_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid_i,
  output logic         push_ready_o,
  input  logic [W-1:0] push_data_i,
  output logic         head_valid_o,
  output logic [W-1:0] head_data_o,
  input  logic         pop_i
);
  localparam int unsigned PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slot_q [DEPTH];
  logic [PTRW-1:0] wr_q, rd_q;
  logic [PTRW:0]   cnt_q;
  logic            do_push, do_pop;

  assign push_ready_o = (cnt_q != (PTRW+1)'(DEPTH));
  assign head_valid_o = (cnt_q != '0);
  assign head_data_o  = slot_q[rd_q];
  assign do_push      = push_valid_i && push_ready_o;
  assign do_pop       = pop_i && head_valid_o;

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTRW'(DEPTH-1)) ? '0 : wr_q + PTRW'(1);
      if (do_pop)  rd_q <= (rd_q == PTRW'(DEPTH-1)) ? '0 : rd_q + PTRW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + (PTRW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (PTRW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/irq_hp_ctl.sv
module irq_hp_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic msg_err_i,
  input  logic irq_en_i,
  input  logic ack_i,
  output logic irq_o,
  output logic hold_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      hold_o <= 1'b0;
    end else begin
      if (evt_i && irq_en_i) irq_o <= 1'b1;
      else if (ack_i)        irq_o <= 1'b0;
      if (evt_i && msg_err_i) hold_o <= 1'b1;
      else if (ack_i)         hold_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_log_seq.sv
module irq_log_seq
  import bcx_irq_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 16,
  parameter logic [AW-1:0] LOG_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ent_valid_i,
  input  logic [DW-1:0] ent_status_i,
  input  logic [AW-1:0] ent_ptr_i,
  input  logic          stall_i,
  output logic          ent_pop_o,
  output logic          done_o,
  output logic          dma_req_o,
  input  logic          dma_gnt_i,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output logic          cmd_we_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_wdata_o,
  input  logic          rvalid_i,
  input  logic [DW-1:0] rdata_i
);
  seq_state_e    state_q;
  logic [AW-1:0] log_ptr_q;
  logic          rd_done;

  assign rd_done   = (state_q == SQ_WAITR) && rvalid_i;
  assign ent_pop_o = rd_done;
  assign done_o    = rd_done;
  assign dma_req_o = (state_q != SQ_IDLE);

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_we_o    = 1'b0;
    cmd_addr_o  = log_ptr_q;
    cmd_wdata_o = '0;
    case (state_q)
      SQ_WSTAT: begin
        cmd_valid_o = 1'b1;
        cmd_we_o    = 1'b1;
        cmd_wdata_o = ent_status_i;
      end
      SQ_WPTR: begin
        cmd_valid_o = 1'b1;
        cmd_we_o    = 1'b1;
        cmd_addr_o  = log_ptr_q + AW'(1);
        cmd_wdata_o = DW'(ent_ptr_i);
      end
      SQ_RTAIL: begin
        cmd_valid_o = 1'b1;
        cmd_addr_o  = log_ptr_q + AW'(2);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      log_ptr_q <= LOG_BASE;
    end else begin
      case (state_q)
        SQ_IDLE:  if (ent_valid_i && !stall_i) state_q <= SQ_ARB;
        SQ_ARB:   if (dma_gnt_i)   state_q <= SQ_WSTAT;
        SQ_WSTAT: if (cmd_ready_i) state_q <= SQ_WPTR;
        SQ_WPTR:  if (cmd_ready_i) state_q <= SQ_RTAIL;
        SQ_RTAIL: if (cmd_ready_i) state_q <= SQ_WAITR;
        SQ_WAITR: if (rvalid_i) begin
          state_q   <= SQ_IDLE;
          log_ptr_q <= rdata_i[AW-1:0];
        end
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_std_out.sv
module irq_std_out (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic lvl_en_i,
  input  logic ack_i,
  output logic pulse_n_o,
  output logic lvl_o
);
  logic pulse_q;

  assign pulse_n_o = ~pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      lvl_o   <= 1'b0;
    end else begin
      pulse_q <= done_i;
      if (done_i && lvl_en_i) lvl_o <= 1'b1;
      else if (ack_i)         lvl_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bcx_irq_unit.sv
module bcx_irq_unit
  import bcx_irq_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter int unsigned   DW       = 16,
  parameter int unsigned   QDEPTH   = 4,
  parameter logic [AW-1:0] LOG_BASE = 16'h0100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hp_evt_i,
  input  logic                hp_msg_err_i,
  input  logic                std_evt_valid_i,
  output logic                std_evt_ready_o,
  input  logic [DW-1:0]       std_status_i,
  input  logic [AW-1:0]       cur_blk_ptr_i,
  input  logic                cfg_en_wr_i,
  input  logic [CFG_W-1:0]    cfg_en_wdata_i,
  input  logic                cfg_ack_wr_i,
  input  logic [CFG_W-1:0]    cfg_ack_wdata_i,
  output logic                hp_irq_o,
  output logic                ctl_hold_o,
  output logic                std_irq_pulse_n_o,
  output logic                std_irq_lvl_o,
  output logic                dma_req_o,
  input  logic                dma_gnt_i,
  output logic                dma_cmd_valid_o,
  input  logic                dma_cmd_ready_i,
  output logic                dma_cmd_we_o,
  output logic [AW-1:0]       dma_cmd_addr_o,
  output logic [DW-1:0]       dma_cmd_wdata_o,
  input  logic                dma_rvalid_i,
  input  logic [DW-1:0]       dma_rdata_i
);
  localparam int unsigned EW = DW + AW;

  logic [CFG_W-1:0] en_q;
  logic [CFG_W-1:0] ack_hit;
  logic             head_valid, head_pop, burst_done;
  logic [EW-1:0]    head_data;

  always_ff @(posedge clk) begin
    if (!rst_n)           en_q <= '0;
    else if (cfg_en_wr_i) en_q <= cfg_en_wdata_i;
  end

  assign ack_hit = cfg_ack_wr_i ? cfg_ack_wdata_i : '0;

  irq_hp_ctl u_hp (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (hp_evt_i),
    .msg_err_i (hp_msg_err_i),
    .irq_en_i  (en_q[CFG_BIT_HP]),
    .ack_i     (ack_hit[CFG_BIT_HP]),
    .irq_o     (hp_irq_o),
    .hold_o    (ctl_hold_o)
  );

  irq_evt_fifo #(.W(EW), .DEPTH(QDEPTH)) u_q (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_valid_i (std_evt_valid_i),
    .push_ready_o (std_evt_ready_o),
    .push_data_i  ({std_status_i, cur_blk_ptr_i}),
    .head_valid_o (head_valid),
    .head_data_o  (head_data),
    .pop_i        (head_pop)
  );

  irq_log_seq #(.AW(AW), .DW(DW), .LOG_BASE(LOG_BASE)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ent_valid_i  (head_valid),
    .ent_status_i (head_data[EW-1:AW]),
    .ent_ptr_i    (head_data[AW-1:0]),
    .stall_i      (ctl_hold_o),
    .ent_pop_o    (head_pop),
    .done_o       (burst_done),
    .dma_req_o    (dma_req_o),
    .dma_gnt_i    (dma_gnt_i),
    .cmd_valid_o  (dma_cmd_valid_o),
    .cmd_ready_i  (dma_cmd_ready_i),
    .cmd_we_o     (dma_cmd_we_o),
    .cmd_addr_o   (dma_cmd_addr_o),
    .cmd_wdata_o  (dma_cmd_wdata_o),
    .rvalid_i     (dma_rvalid_i),
    .rdata_i      (dma_rdata_i)
  );

  irq_std_out u_std (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_i    (burst_done),
    .lvl_en_i  (en_q[CFG_BIT_STD]),
    .ack_i     (ack_hit[CFG_BIT_STD]),
    .pulse_n_o (std_irq_pulse_n_o),
    .lvl_o     (std_irq_lvl_o)
  );
endmodule

// File: rtl/bcx_irq_unit_chk.sv
module bcx_irq_unit_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hp_evt_i,
  input logic          hp_msg_err_i,
  input logic          cfg_ack_wr_i,
  input logic [1:0]    cfg_ack_wdata_i,
  input logic          hp_irq_o,
  input logic          ctl_hold_o,
  input logic          std_irq_pulse_n_o,
  input logic          std_irq_lvl_o,
  input logic          dma_req_o,
  input logic          dma_cmd_valid_o,
  input logic          dma_cmd_ready_i,
  input logic          dma_cmd_we_o,
  input logic [AW-1:0] dma_cmd_addr_o,
  input logic [DW-1:0] dma_cmd_wdata_o
);
  AST_CMD_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dma_cmd_valid_o |-> dma_req_o); // R4

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dma_cmd_valid_o && !dma_cmd_ready_i |=> dma_cmd_valid_o && $stable(dma_cmd_we_o)
      && $stable(dma_cmd_addr_o) && $stable(dma_cmd_wdata_o)); // R12

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !std_irq_pulse_n_o |=> std_irq_pulse_n_o); // R6

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hold_o && !(cfg_ack_wr_i && cfg_ack_wdata_i[0]) |=> ctl_hold_o); // R3

  AST_HOLD_FROM_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_hold_o) |-> $past(hp_evt_i && hp_msg_err_i)); // R11

  AST_NO_START_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hold_o && !dma_req_o |=> !dma_req_o); // R9

  AST_HP_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hp_irq_o) |-> $past(hp_evt_i)); // R2

  AST_LVL_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(std_irq_lvl_o) |-> !std_irq_pulse_n_o); // R7
endmodule

bind bcx_irq_unit bcx_irq_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .hp_evt_i          (hp_evt_i),
  .hp_msg_err_i      (hp_msg_err_i),
  .cfg_ack_wr_i      (cfg_ack_wr_i),
  .cfg_ack_wdata_i   (cfg_ack_wdata_i),
  .hp_irq_o          (hp_irq_o),
  .ctl_hold_o        (ctl_hold_o),
  .std_irq_pulse_n_o (std_irq_pulse_n_o),
  .std_irq_lvl_o     (std_irq_lvl_o),
  .dma_req_o         (dma_req_o),
  .dma_cmd_valid_o   (dma_cmd_valid_o),
  .dma_cmd_ready_i   (dma_cmd_ready_i),
  .dma_cmd_we_o      (dma_cmd_we_o),
  .dma_cmd_addr_o    (dma_cmd_addr_o),
  .dma_cmd_wdata_o   (dma_cmd_wdata_o)
);

// File: tb/tb_bcx_irq_unit.sv
`timescale 1ns/1ps
module tb_bcx_irq_unit;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 16;
  localparam int unsigned QD = 4;
  localparam logic [AW-1:0] BASE = 16'h0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hp_evt = 1'b0, hp_err = 1'b0;
  logic sv = 1'b0, sr;
  logic [DW-1:0] s_stat = '0;
  logic [AW-1:0] s_ptr = '0;
  logic en_wr = 1'b0, ack_wr = 1'b0;
  logic [1:0] en_d = '0, ack_d = '0;
  logic hp_irq, hold, pls_n, lvl, req, gnt, cv, cr, cwe, rv;
  logic [AW-1:0] caddr;
  logic [DW-1:0] cwd, rd;

  always #4 clk = ~clk;

  bcx_irq_unit #(.AW(AW), .DW(DW), .QDEPTH(QD), .LOG_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .hp_evt_i(hp_evt), .hp_msg_err_i(hp_err),
    .std_evt_valid_i(sv), .std_evt_ready_o(sr), .std_status_i(s_stat),
    .cur_blk_ptr_i(s_ptr), .cfg_en_wr_i(en_wr), .cfg_en_wdata_i(en_d),
    .cfg_ack_wr_i(ack_wr), .cfg_ack_wdata_i(ack_d), .hp_irq_o(hp_irq),
    .ctl_hold_o(hold), .std_irq_pulse_n_o(pls_n), .std_irq_lvl_o(lvl),
    .dma_req_o(req), .dma_gnt_i(gnt), .dma_cmd_valid_o(cv),
    .dma_cmd_ready_i(cr), .dma_cmd_we_o(cwe), .dma_cmd_addr_o(caddr),
    .dma_cmd_wdata_o(cwd), .dma_rvalid_i(rv), .dma_rdata_i(rd)
  );

  int n_vec = 0, n_bad = 0;
  logic [DW-1:0] mem [256];
  logic [AW:0]   mon [64];
  int  mon_cnt = 0, exp_mon = 0, cyc = 0;
  bit  stall_mode = 0, gnt_block = 0, rd_pend = 0;
  logic [AW-1:0] rd_addr = '0, lp = BASE;
  logic [1:0] en_cur = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory / arbiter model, acts at the falling edge
  initial begin
    cr = 1'b1; rv = 1'b0; rd = '0; gnt = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      rv = 1'b0;
      if (rd_pend) begin
        rv = 1'b1;
        rd = rd_addr * 16'd5 + 16'd11;
        rd_pend = 0;
      end
      cr  = stall_mode ? ((cyc % 3) != 0) : 1'b1;
      gnt = req && !gnt_block;
      if (cv && cr) begin
        mon[mon_cnt % 64] = {cwe, caddr};
        mon_cnt++;
        if (cwe) mem[caddr[7:0]] = cwd;
        else begin rd_pend = 1; rd_addr = caddr; end
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic set_en(input logic [1:0] v);
    en_wr = 1'b1; en_d = v; en_cur = v; tick(); en_wr = 1'b0;
  endtask

  task automatic do_ack(input logic [1:0] v);
    ack_wr = 1'b1; ack_d = v; tick(); ack_wr = 1'b0; ack_d = '0;
  endtask

  task automatic push(input logic [DW-1:0] st, input logic [AW-1:0] p);
    while (!sr) tick();
    sv = 1'b1; s_stat = st; s_ptr = p; tick(); sv = 1'b0;
  endtask

  // waits for the pulse and checks the completed burst (R4 R5 R6 R7 R11)
  task automatic expect_burst(input logic [DW-1:0] st, input logic [AW-1:0] p, input bit lvl_exp);
    bit got = 0;
    logic [AW-1:0] nx;
    for (int i = 0; i < 400; i++) begin
      if (!pls_n) begin got = 1; break; end
      tick();
    end
    check(got, "R6 pulse seen", {31'b0, got}, 1);
    check(lvl == lvl_exp, "R7 level at pulse", {31'b0, lvl}, {31'b0, lvl_exp});
    check(!hold, "R11 no hold after std", {31'b0, hold}, 0);
    tick();
    check(pls_n, "R6 pulse one cycle", {31'b0, pls_n}, 1);
    check(mon_cnt - exp_mon == 3, "R4 three commands", mon_cnt - exp_mon, 3);
    check(mon[exp_mon % 64] == {1'b1, lp}, "R4 status write addr", mon[exp_mon % 64], {1'b1, lp});
    check(mon[(exp_mon+1) % 64] == {1'b1, lp + 16'd1}, "R4 pointer write addr",
          mon[(exp_mon+1) % 64], {1'b1, lp + 16'd1});
    check(mon[(exp_mon+2) % 64] == {1'b0, lp + 16'd2}, "R5 tail read addr",
          mon[(exp_mon+2) % 64], {1'b0, lp + 16'd2});
    check(mem[lp[7:0]] == st, "R4 status logged", mem[lp[7:0]], st);
    nx = lp + 16'd1;
    check(mem[nx[7:0]] == p, "R4 pointer logged", mem[nx[7:0]], p);
    exp_mon += 3;
    nx = lp + 16'd2;
    lp = nx * 16'd5 + 16'd11;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(!hp_irq && !hold && !lvl && !req && !cv, "R1 outputs low",
          {27'b0, hp_irq, hold, lvl, req, cv}, 0);
    check(pls_n && sr, "R1 pulse high ready high", {30'b0, pls_n, sr}, 3);

    // high-priority sweep: enable x message error (R2 R3 R8)
    for (int en = 0; en < 2; en++) begin
      for (int er = 0; er < 2; er++) begin
        set_en({1'b0, en[0]});
        hp_evt = 1'b1; hp_err = er[0]; tick(); hp_evt = 1'b0; hp_err = 1'b0;
        check(hp_irq == en[0], "R2 hp irq gated by enable", {31'b0, hp_irq}, en);
        check(hold == er[0], "R3 hold on message error", {31'b0, hold}, er);
        repeat (3) tick();
        check(hp_irq == en[0] && hold == er[0], "R3 flags persist", {30'b0, hp_irq, hold}, {30'b0, en[0], er[0]});
        do_ack(2'b10);
        check(hp_irq == en[0] && hold == er[0], "R8 zero ack bit ignored", {30'b0, hp_irq, hold}, {30'b0, en[0], er[0]});
        do_ack(2'b01);
        check(!hp_irq && !hold, "R3 ack clears hp and hold", {30'b0, hp_irq, hold}, 0);
      end
    end
    set_en(2'b01);
    hp_evt = 1'b1; hp_err = 1'b1; ack_wr = 1'b1; ack_d = 2'b01;
    tick();
    hp_evt = 1'b0; hp_err = 1'b0; ack_wr = 1'b0; ack_d = '0;
    check(hp_irq && hold, "R8 set wins over clear", {30'b0, hp_irq, hold}, 3);
    do_ack(2'b01);

    // standard sweep: level enable x command back-pressure (R4 R5 R6 R7 R8 R12)
    for (int le = 0; le < 2; le++) begin
      for (int st = 0; st < 2; st++) begin
        stall_mode = st[0];
        set_en({le[0], 1'b1});
        for (int k = 0; k < 3; k++) begin
          logic [DW-1:0] sw;
          logic [AW-1:0] pw;
          sw = 16'hA000 + 16'(le * 256 + st * 16 + k);
          pw = 16'h3000 + 16'(k * 7 + st);
          push(sw, pw);
          expect_burst(sw, pw, le[0]);
          do_ack(2'b01);
          check(lvl == le[0], "R8 other ack bit ignored", {31'b0, lvl}, le);
          do_ack(2'b10);
          check(!lvl, "R7 ack clears level", {31'b0, lvl}, 0);
        end
      end
    end
    stall_mode = 0;

    // queue fill with grant withheld (R10)
    gnt_block = 1;
    set_en(2'b10);
    for (int k = 0; k < 4; k++) push(16'hC000 + 16'(k), 16'h0500 + 16'(k));
    check(!sr, "R10 ready low when full", {31'b0, sr}, 0);
    check(req && !cv, "R4 waits for grant", {30'b0, req, cv}, 2);
    gnt_block = 0;
    for (int k = 0; k < 4; k++) begin
      expect_burst(16'hC000 + 16'(k), 16'h0500 + 16'(k), 1'b1);
      check(sr, "R10 ready returns after pop", {31'b0, sr}, 1);
      do_ack(2'b10);
    end

    // simultaneous high-priority error and standard event (R9)
    set_en(2'b11);
    hp_evt = 1'b1; hp_err = 1'b1; sv = 1'b1; s_stat = 16'hE55E; s_ptr = 16'h0777;
    tick();
    hp_evt = 1'b0; hp_err = 1'b0; sv = 1'b0;
    begin
      bit any_req = 0;
      for (int i = 0; i < 12; i++) begin
        if (req) any_req = 1;
        tick();
      end
      check(!any_req, "R9 no burst during hold", {31'b0, any_req}, 0);
    end
    check(hold && hp_irq, "R9 hold serviced first", {30'b0, hold, hp_irq}, 3);
    do_ack(2'b01);
    check(!hold, "R3 hold released", {31'b0, hold}, 0);
    expect_burst(16'hE55E, 16'h0777, 1'b1);
    do_ack(2'b10);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule